// File: doc/BRIEF.md
# Receive Character Queue with Fill-Level Interrupts

This block sits on the receive side of a serial port, just after the bit-level deserializer. Each completed character arrives with its data bits, a framing-error bit and a parity-error bit, all marked by a one-cycle strobe that means "stop bit seen". The character first lands in a single holding stage. From there it moves into a four-word circular buffer as soon as a slot is free. Software, or a bus front end, pops words from the head with a read strobe. The head word's two error bits are shown next to its data, so each error bit always belongs to the word on display.

An interrupt pulse reports transfers from the holding stage into the buffer. A 2-bit select chooses when the pulse fires: on every transfer, only when a transfer leaves exactly three words stored, or only when a transfer fills the buffer. The buffer and the holding stage together store five characters.

A further character that arrives while all five places are occupied raises a sticky overrun flag. From then on new characters are refused until a clear pulse arrives. The stored words remain readable during this time. A read from an empty buffer does not move any pointer, and the head keeps showing the word it showed before.

Top module: `rx_char_queue`

## Requirements
- R1: With no reads, five characters are accepted without loss: four in the buffer and one in the holding stage. Fill level never exceeds four.
- R2: `data_avail` is 1 exactly when the buffer holds at least one word.
- R3: `rd_en` while the buffer is empty moves nothing. `head_data`, `head_ferr` and `head_perr` keep the value of the last word popped, or zero after reset.
- R4: Words leave in arrival order. Each read shows the next word at the head, together with its own framing bit (`chr_ferr`) and parity bit (`chr_perr`).
- R5: With `irq_sel` = 2'b00 or 2'b01, `irq_pulse` is high for one cycle after every clock edge on which a word moves from the holding stage into the buffer.
- R6: With `irq_sel` = 2'b10, the pulse fires only after a transfer that leaves the buffer holding exactly 3 words. The level counts any read on the same edge.
- R7: With `irq_sel` = 2'b11, the pulse fires only after a transfer that leaves the buffer holding 4 words.
- R8: `ovf_flag` sets when `chr_valid` arrives with the buffer full, the holding stage occupied and no read on that edge. While it is set, `chr_valid` is ignored, and the stored words and the held character stay intact.
- R9: A one-cycle `ovf_clr` clears `ovf_flag` on the next edge. It wins over a set condition on the same edge, and the character arriving on that edge is dropped.
- R10: A synchronous active-low reset empties the buffer and the holding stage. It clears `ovf_flag`, `irq_pulse` and `data_avail`, and the head outputs read zero.
- R11: When a read pops a full buffer while the holding stage is occupied, the held character enters the buffer on the same edge, so the fill level stays at four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chr_valid | input | 1 | One-cycle strobe: a character has completed (stop bit detected) |
| chr_data | input | DATA_W | Data bits of the completed character |
| chr_ferr | input | 1 | Framing error of the completed character |
| chr_perr | input | 1 | Parity error of the completed character |
| rd_en | input | 1 | Pop the head word |
| head_data | output | DATA_W | Data of the head word (stale when empty) |
| head_ferr | output | 1 | Framing error of the head word |
| head_perr | output | 1 | Parity error of the head word |
| data_avail | output | 1 | Buffer holds at least one word |
| ovf_flag | output | 1 | Sticky overrun indication |
| ovf_clr | input | 1 | One-cycle overrun clear |
| irq_sel | input | 2 | Interrupt mode select |
| irq_pulse | output | 1 | One-cycle receive interrupt |

## Verification
The hardest corner to reach is an edge on which a new character, a read and a full buffer with an occupied holding stage all meet. That edge decides between R11 (the read makes room and nothing is lost) and R8 (overrun). Directed sequences first fill all five places, then present a strobe with and without a simultaneous read, and then with a simultaneous clear. A long random phase mixes strobes, reads, clears and changes of interrupt mode, so that the same coincidences occur many more times. A queue-based model in the bench checks every output on every cycle.

// File: rtl/rxq_pkg.sv
// Package rxq_pkg
// Shared definitions for the receive character queue: interrupt mode
// encoding and the layout of a stored word {ferr, perr, data}.
package rxq_pkg;

    // Interrupt select encoding; the values are decoded from the irq_sel port.
    typedef enum logic [1:0] {
        IRQ_EACH_LO = 2'b00,
        IRQ_EACH_HI = 2'b01,
        IRQ_LEVEL3  = 2'b10,
        IRQ_FULL    = 2'b11
    } irq_mode_e;

    // Bit offsets of the error flags inside a stored word of width w.
    function automatic int ferr_bit(input int w);
        return w - 1;
    endfunction

    function automatic int perr_bit(input int w);
        return w - 2;
    endfunction

endpackage

// File: rtl/rxq_hold_stage.sv
// Module rxq_hold_stage
// Single-character holding stage between the deserializer and the buffer.
// Accepts a completed character when it is empty or empties on the same
// edge, hands it to the buffer whenever a slot exists (including a slot
// freed by a read on the same edge), and raises a sticky overrun flag when
// a character arrives with nowhere to go.
// Assumes: chr_valid and ovf_clr are single-cycle pulses.
module rxq_hold_stage #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_valid,
    input  logic [WORD_W-1:0] chr_word,
    input  logic              buf_full,
    input  logic              rd_pop,
    input  logic              ovf_clr,
    output logic [WORD_W-1:0] hold_word,
    output logic              hold_full,
    output logic              xfer,
    output logic              ovf_flag
);

    logic hold_busy;
    logic accept;
    logic ovr_set;

    // Transfer decision: stage occupied and the buffer has or gains a slot.
    always_comb begin
        xfer      = hold_full && (!buf_full || rd_pop);
        hold_busy = hold_full && !xfer;
        accept    = chr_valid && !ovf_flag && !hold_busy;
        ovr_set   = chr_valid && !ovf_flag && hold_busy;
    end

    // Holding register: load on accept, empty on transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_word <= '0;
        end else if (accept) begin
            hold_full <= 1'b1;
            hold_word <= chr_word;
        end else if (xfer) begin
            hold_full <= 1'b0;
        end
    end

    // Sticky overrun flag; the clear pulse has priority over a set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (ovf_clr) begin
            ovf_flag <= 1'b0;
        end else if (ovr_set) begin
            ovf_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/rxq_ring.sv
// Module rxq_ring
// Circular word buffer with a fill counter. Pops only when non-empty;
// when empty, the head shows the slot just behind the read pointer, which
// holds the last word popped (zero after reset), so an empty read leaves
// the head unchanged.
// Assumes: DEPTH is a power of two and at least 2; the writer only writes
// when a slot exists (guaranteed by the holding stage).
module rxq_ring #(
    parameter int WORD_W = 10,
    parameter int DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       xfer,
    input  logic [WORD_W-1:0]          wr_word,
    input  logic                       rd_en,
    output logic [WORD_W-1:0]          head_word,
    output logic [$clog2(DEPTH+1)-1:0] fill_cnt,
    output logic [$clog2(DEPTH+1)-1:0] cnt_after,
    output logic                       buf_full,
    output logic                       rd_pop
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  rd_ptr_prev;
    logic [DEPTH-1:0]  slot_we;

    // Per-slot write enable decoded from the write pointer.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot_we
        assign slot_we[i] = xfer && (wr_ptr == PTR_W'(i));
    end

    // Pop qualification and the fill level after this edge.
    always_comb begin
        rd_pop   = rd_en && (fill_cnt != '0);
        buf_full = (fill_cnt == CNT_W'(DEPTH));
        case ({xfer, rd_pop})
            2'b10:   cnt_after = fill_cnt + CNT_W'(1);
            2'b01:   cnt_after = fill_cnt - CNT_W'(1);
            default: cnt_after = fill_cnt;
        endcase
    end

    // Head selection: live head when non-empty, last popped word otherwise.
    always_comb begin
        rd_ptr_prev = rd_ptr - PTR_W'(1);
        head_word   = (fill_cnt == '0) ? mem[rd_ptr_prev] : mem[rd_ptr];
    end

    // Storage slots, cleared on reset so the idle head reads zero.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (slot_we[i]) begin
                mem[i] <= wr_word;
            end
        end
    end

    // Pointers and fill counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            fill_cnt <= '0;
        end else begin
            if (xfer)   wr_ptr <= wr_ptr + PTR_W'(1);
            if (rd_pop) rd_ptr <= rd_ptr + PTR_W'(1);
            fill_cnt <= cnt_after;
        end
    end

endmodule

// File: rtl/rxq_irq_gen.sv
// Module rxq_irq_gen
// Receive interrupt pulse generator. Registers a one-cycle pulse after a
// transfer edge whose resulting fill level matches the selected mode.
// Assumes: cnt_after is the fill level after the current edge.
module rxq_irq_gen #(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       xfer,
    input  logic [$clog2(DEPTH+1)-1:0] cnt_after,
    input  logic [1:0]                 irq_sel,
    output logic                       irq_pulse
);
    import rxq_pkg::*;

    localparam int CNT_W = $clog2(DEPTH+1);

    logic      level_hit;
    irq_mode_e mode;

    // Mode decode: compare the post-transfer level with the threshold.
    always_comb begin
        mode = irq_mode_e'(irq_sel);
        case (mode)
            IRQ_LEVEL3: level_hit = (cnt_after == CNT_W'(DEPTH - 1));
            IRQ_FULL:   level_hit = (cnt_after == CNT_W'(DEPTH));
            default:    level_hit = 1'b1;
        endcase
    end

    // Pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= xfer && level_hit;
        end
    end

endmodule

// File: rtl/rx_char_queue.sv
// Module rx_char_queue
// Receive-side character queue of a serial port: a holding stage feeding a
// DEPTH-word buffer, per-word error flags, a sticky overrun flag and a
// fill-threshold interrupt pulse.
// Assumes: chr_valid, ovf_clr and rd_en are synchronous to clk; DEPTH is a
// power of two, at least 2.
module rx_char_queue #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_valid,
    input  logic [DATA_W-1:0] chr_data,
    input  logic              chr_ferr,
    input  logic              chr_perr,
    input  logic              rd_en,
    output logic [DATA_W-1:0] head_data,
    output logic              head_ferr,
    output logic              head_perr,
    output logic              data_avail,
    output logic              ovf_flag,
    input  logic              ovf_clr,
    input  logic [1:0]        irq_sel,
    output logic              irq_pulse
);
    import rxq_pkg::*;

    localparam int WORD_W = DATA_W + 2;
    localparam int CNT_W  = $clog2(DEPTH+1);
    localparam int FE_B   = ferr_bit(WORD_W);
    localparam int PE_B   = perr_bit(WORD_W);

    logic [WORD_W-1:0] in_word;
    logic [WORD_W-1:0] hold_word;
    logic [WORD_W-1:0] head_word;
    logic              hold_full;
    logic              xfer;
    logic              buf_full;
    logic              rd_pop;
    logic [CNT_W-1:0]  fill_cnt;
    logic [CNT_W-1:0]  cnt_after;

    // Pack the incoming character with its error flags.
    assign in_word = {chr_ferr, chr_perr, chr_data};

    rxq_hold_stage #(.WORD_W(WORD_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .chr_valid (chr_valid),
        .chr_word  (in_word),
        .buf_full  (buf_full),
        .rd_pop    (rd_pop),
        .ovf_clr   (ovf_clr),
        .hold_word (hold_word),
        .hold_full (hold_full),
        .xfer      (xfer),
        .ovf_flag  (ovf_flag)
    );

    rxq_ring #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer      (xfer),
        .wr_word   (hold_word),
        .rd_en     (rd_en),
        .head_word (head_word),
        .fill_cnt  (fill_cnt),
        .cnt_after (cnt_after),
        .buf_full  (buf_full),
        .rd_pop    (rd_pop)
    );

    rxq_irq_gen #(.DEPTH(DEPTH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer      (xfer),
        .cnt_after (cnt_after),
        .irq_sel   (irq_sel),
        .irq_pulse (irq_pulse)
    );

    // Unpack the head word and derive the availability flag.
    always_comb begin
        head_data  = head_word[DATA_W-1:0];
        head_ferr  = head_word[FE_B];
        head_perr  = head_word[PE_B];
        data_avail = (fill_cnt != '0);
    end

endmodule

// File: rtl/rxq_checker.sv
// Module rxq_checker
// Property checker for rx_char_queue, attached with bind below.
module rxq_checker #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rd_en,
    input logic                       xfer,
    input logic                       hold_full,
    input logic [$clog2(DEPTH+1)-1:0] fill_cnt,
    input logic                       data_avail,
    input logic [DATA_W-1:0]          head_data,
    input logic                       head_ferr,
    input logic                       head_perr,
    input logic                       ovf_flag,
    input logic                       ovf_clr,
    input logic [1:0]                 irq_sel,
    input logic                       irq_pulse
);
    localparam int CNT_W = $clog2(DEPTH+1);

    // R1: fill level bounded by the buffer depth
    assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CNT_W'(DEPTH));

    // R3: empty read with no incoming transfer keeps the head stable
    assert_stale_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_avail && rd_en && !xfer) |=>
            ($stable(head_data) && $stable(head_ferr) && $stable(head_perr)));

    // R6: level-3 mode pulses only with three words stored
    assert_irq_level3_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && $past(irq_sel) == 2'b10) |-> fill_cnt == CNT_W'(DEPTH - 1));

    // R7: full mode pulses only with the buffer full
    assert_irq_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && $past(irq_sel) == 2'b11) |-> fill_cnt == CNT_W'(DEPTH));

    // R8: overrun is sticky until cleared
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R9: a clear pulse always wins
    assert_ovf_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr |=> !ovf_flag);

    // R11: a read from a full buffer with a held character keeps it full
    assert_refill_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hold_full && fill_cnt == CNT_W'(DEPTH)) |=> fill_cnt == CNT_W'(DEPTH));

endmodule

bind rx_char_queue rxq_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .xfer       (xfer),
    .hold_full  (hold_full),
    .fill_cnt   (fill_cnt),
    .data_avail (data_avail),
    .head_data  (head_data),
    .head_ferr  (head_ferr),
    .head_perr  (head_perr),
    .ovf_flag   (ovf_flag),
    .ovf_clr    (ovf_clr),
    .irq_sel    (irq_sel),
    .irq_pulse  (irq_pulse)
);

// File: tb/rx_char_queue_bench.sv
// Bench for rx_char_queue: behavioural queue model compared on every cycle.
module rx_char_queue_bench;

    localparam int DW    = 8;
    localparam int DEPTH = 4;
    localparam int WW    = DW + 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          chr_valid;
    logic [DW-1:0] chr_data;
    logic          chr_ferr;
    logic          chr_perr;
    logic          rd_en;
    logic [DW-1:0] head_data;
    logic          head_ferr;
    logic          head_perr;
    logic          data_avail;
    logic          ovf_flag;
    logic          ovf_clr;
    logic [1:0]    irq_sel;
    logic          irq_pulse;

    int checks = 0;
    int errors = 0;
    string tag = "R10";

    // Model state
    logic [WW-1:0] q[$];
    logic          m_hv;
    logic [WW-1:0] m_hw;
    logic          m_ovf;
    logic          m_irq;
    logic [WW-1:0] m_last;

    always #2 clk = ~clk;

    rx_char_queue #(.DATA_W(DW), .DEPTH(DEPTH)) u_rx_char_queue (
        .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
        .chr_ferr(chr_ferr), .chr_perr(chr_perr), .rd_en(rd_en),
        .head_data(head_data), .head_ferr(head_ferr), .head_perr(head_perr),
        .data_avail(data_avail), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr),
        .irq_sel(irq_sel), .irq_pulse(irq_pulse)
    );

    task automatic check1(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [WW-1:0] eh;
        eh = (q.size() != 0) ? q[0] : m_last;
        check1("head_data", 32'(head_data), 32'(eh[DW-1:0]));
        check1("head_ferr", 32'(head_ferr), 32'(eh[WW-1]));
        check1("head_perr", 32'(head_perr), 32'(eh[WW-2]));
        check1("data_avail", 32'(data_avail), 32'(q.size() != 0));
        check1("ovf_flag", 32'(ovf_flag), 32'(m_ovf));
        check1("irq_pulse", 32'(irq_pulse), 32'(m_irq));
    endtask

    task automatic model_reset();
        q.delete();
        m_hv = 1'b0; m_hw = '0; m_ovf = 1'b0; m_irq = 1'b0; m_last = '0;
    endtask

    // One clock: drive, advance the model, sample at the following negedge.
    task automatic step(input logic cv, input logic [DW-1:0] d, input logic fe,
                        input logic pe, input logic rd, input logic clr,
                        input logic [1:0] sel);
        logic pop, xf, busy;
        int   after;
        chr_valid = cv; chr_data = d; chr_ferr = fe; chr_perr = pe;
        rd_en = rd; ovf_clr = clr; irq_sel = sel;
        pop   = rd && (q.size() != 0);
        xf    = m_hv && (q.size() < DEPTH || pop);
        busy  = m_hv && !xf;
        after = q.size() + (xf ? 1 : 0) - (pop ? 1 : 0);
        m_irq = xf && ((sel[1] == 1'b0) || (sel == 2'b10 && after == DEPTH - 1)
                       || (sel == 2'b11 && after == DEPTH));
        if (pop) m_last = q.pop_front();
        if (xf) begin q.push_back(m_hw); m_hv = 1'b0; end
        if (cv && !m_ovf) begin
            if (busy) begin
                if (!clr) m_ovf = 1'b1;
            end else begin
                m_hv = 1'b1; m_hw = {fe, pe, d};
            end
        end
        if (clr) m_ovf = 1'b0;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic put(input logic [DW-1:0] d, input logic fe, input logic pe,
                       input logic [1:0] sel);
        step(1'b1, d, fe, pe, 1'b0, 1'b0, sel);
    endtask

    task automatic idle(input int n, input logic [1:0] sel);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, sel);
    endtask

    task automatic pop1(input logic [1:0] sel);
        step(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, sel);
    endtask

    task automatic drain(input logic [1:0] sel);
        for (int i = 0; i < 8; i++) pop1(sel);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        chr_valid = 0; chr_data = '0; chr_ferr = 0; chr_perr = 0;
        rd_en = 0; ovf_clr = 0; irq_sel = 2'b00;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_all();
    endtask

    // Watchdog
    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state
        tag = "R10";
        do_reset();

        // R5, R4: single words with error flags, mode 00 and 01
        tag = "R5";
        put(8'hA5, 1'b1, 1'b0, 2'b00);
        idle(2, 2'b00);
        tag = "R4";
        put(8'h3C, 1'b0, 1'b1, 2'b01);
        idle(2, 2'b01);
        pop1(2'b01);
        pop1(2'b01);
        // R3: empty reads keep the last popped word
        tag = "R3";
        pop1(2'b01);
        pop1(2'b01);
        tag = "R2";
        idle(1, 2'b01);

        // R1, R7: fill all five places, mode 11
        tag = "R7";
        for (int i = 0; i < 5; i++) put(8'(8'h10 + i), i[0], i[1], 2'b11);
        tag = "R1";
        idle(2, 2'b11);
        // R8: sixth character overruns, further ones ignored
        tag = "R8";
        put(8'hEE, 1'b1, 1'b1, 2'b11);
        put(8'hEF, 1'b0, 1'b0, 2'b11);
        pop1(2'b11);
        put(8'hF0, 1'b0, 1'b0, 2'b11);
        idle(1, 2'b11);
        // R9: clear pulse
        tag = "R9";
        step(1'b0, '0, 0, 0, 1'b0, 1'b1, 2'b11);
        put(8'h55, 1'b0, 1'b0, 2'b11);
        // R9: clear together with a set condition
        step(1'b1, 8'h66, 0, 0, 1'b0, 1'b1, 2'b11);
        idle(1, 2'b11);
        // R11: read from full buffer with held character, new char same edge
        tag = "R11";
        step(1'b1, 8'h77, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11);
        pop1(2'b11);
        idle(1, 2'b11);
        tag = "R4";
        drain(2'b00);

        // R6: level-3 mode
        tag = "R6";
        for (int i = 0; i < 5; i++) put(8'(8'h80 + i), 1'b0, i[0], 2'b10);
        idle(2, 2'b10);
        pop1(2'b10);
        pop1(2'b10);
        idle(2, 2'b10);
        drain(2'b10);

        // R10: reset mid-stream empties everything
        tag = "R10";
        put(8'h99, 1'b1, 1'b1, 2'b00);
        idle(1, 2'b00);
        do_reset();

        // R4: random mix of strobes, reads, clears and mode changes
        tag = "R4";
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 10) < 4, 8'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 10) < 3, ($urandom % 40) == 0, 2'($urandom / 97));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule